// File: doc/BRIEF.md
# Dual-Mode Serial Receiver with Status Flags

This block receives serial bytes in one of two frame modes and reports them through a small status stage. In asynchronous mode (`mode_sel` = 0) a frame is a low start bit, eight data bits sent least significant first, a ninth bit that marks the frame as an address (1) or data (0), and a high stop bit. Every bit lasts 16 pulses of an oversample tick, and the line is sampled in the middle of each bit. In synchronous mode (`mode_sel` = 1) eight data bits, least significant first, are taken from the serial input on each pulse of an external shift-clock strobe. This mode has no start bit and no stop bit.

When a frame completes, the status stage loads the byte into a holding register and sets the receive-full flag. It sets the overrun flag if the previous byte has not been read yet. It sets the framing-error flag if the asynchronous stop bit was sampled low. A byte is reported valid only while no error flag is set. The interrupt request is the OR of all flags, gated by an enable input. Reading clears receive-full, and a separate strobe clears both error flags. Baud generation and transmission are outside the block.

Top module: `dual_mode_rx`

## Requirements
- R1: In asynchronous mode (`mode_sel`=0) a start is accepted only if the line is still low 8 ticks after the falling edge. A shorter low pulse produces no frame. After an accepted start, each of the nine following bits is sampled 16 ticks after the previous sample. Bits 0..7 land LSB first in `rx_data` and bit 8 lands in `rx_addr`.
- R2: In asynchronous mode, none of `rx_full`, `ovr_err` or `frm_err` changes before the stop bit is sampled. All of them update together on the clock edge after the stop-bit sample.
- R3: In asynchronous mode, a stop bit sampled as 0 sets `frm_err`. The byte and `rx_full` are still loaded.
- R4: In synchronous mode (`mode_sel`=1), `ser_in` is taken on each cycle in which `sclk_stb` is high, as bits 0..7 LSB first. The flags update on the clock edge after the edge that takes the eighth bit, and `rx_addr` reads 0.
- R5: Synchronous mode never sets `frm_err`.
- R6: If a frame completes while `rx_full` is set and `rd_stb` is low in that cycle, `ovr_err` is set. `rx_data` and `rx_addr` keep the earlier byte and the new byte is discarded.
- R7: `rd_stb` clears `rx_full`, and `err_clr` clears `ovr_err` and `frm_err`. When a flag is set and cleared in the same cycle, the set wins.
- R8: `data_valid` is high exactly when `rx_full` is set and neither `ovr_err` nor `frm_err` is set.
- R9: `irq` equals `irq_en` AND (`rx_full` OR `ovr_err` OR `frm_err`), so it stays high until every flag is cleared.
- R10: After a synchronous reset all flags, `rx_data`, `rx_addr`, `data_valid` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = asynchronous 9-bit mode, 1 = synchronous 8-bit mode |
| ser_in | input | 1 | Serial data input |
| os_tick | input | 1 | 16x oversample tick (asynchronous mode) |
| sclk_stb | input | 1 | Shift-clock strobe, one bit per pulse (synchronous mode) |
| rd_stb | input | 1 | Data-register read strobe, clears receive-full |
| err_clr | input | 1 | Clears overrun and framing error |
| irq_en | input | 1 | Receive interrupt enable |
| rx_data | output | 8 | Held received byte |
| rx_addr | output | 1 | Address/data marker of the held byte |
| rx_full | output | 1 | Receive-full flag |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing-error flag |
| data_valid | output | 1 | Held byte is usable |
| irq | output | 1 | Receive interrupt request |

## Verification
With the tick high on every clock, an asynchronous stop bit is sampled 168 cycles after the start edge, and the flags appear one cycle later. The bench therefore samples once at the start of the stop bit, where nothing may have changed yet, and again after the full stop bit plus idle cycles. In synchronous mode the flags follow the eighth strobe by two clock edges. The bench checks "no change yet" after the seventh strobe and checks the result two falling edges after the eighth. All sampling is done on falling edges, well clear of the edges where the values change.

// File: rtl/dmrx_pkg.sv
package dmrx_pkg;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 1;

    typedef enum logic {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } rx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP
    } async_st_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic               stop_bad;
    } rx_frame_t;

    function automatic logic [FRAME_W-1:0] put_bit(
        input logic [FRAME_W-1:0] cur,
        input int unsigned        pos,
        input logic               b
    );
        logic [FRAME_W-1:0] r;
        r = cur;
        r[pos] = b;
        return r;
    endfunction
endpackage

// File: rtl/dmrx_async.sv
module dmrx_async
    import dmrx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      os_tick,
    input  logic      ser_in,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW  = $clog2(OS_RATE);
    localparam int IW  = $clog2(FRAME_W);
    localparam logic [CW-1:0] MID  = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);
    localparam logic [IW-1:0] TOPB = IW'(FRAME_W - 1);

    async_st_e          state;
    logic [CW-1:0]      cnt;
    logic [IW-1:0]      idx;
    logic [FRAME_W-1:0] shreg;
    logic               stop_bad;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            stop_bad <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                case (state)
                    ST_IDLE: begin
                        cnt <= '0;
                        if (!ser_in) state <= ST_START;
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt   <= '0;
                            idx   <= '0;
                            state <= ser_in ? ST_IDLE : ST_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BITS: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= put_bit(shreg, 32'(idx), ser_in);
                            if (idx == TOPB) state <= ST_STOP;
                            else idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == LAST) begin
                            cnt      <= '0;
                            stop_bad <= ~ser_in;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign frame = '{bits: shreg, stop_bad: stop_bad};

    // R2
    async_done_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state == ST_STOP && os_tick));
endmodule

// File: rtl/dmrx_sync.sv
module dmrx_sync
    import dmrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      sclk_stb,
    input  logic      ser_in,
    output logic      done,
    output rx_frame_t frame
);
    localparam int IW = $clog2(DATA_W);
    localparam logic [IW-1:0] TOPB = IW'(DATA_W - 1);

    logic [IW-1:0]      idx;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx   <= '0;
            shreg <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (sclk_stb) begin
                shreg <= put_bit(shreg, 32'(idx), ser_in);
                if (idx == TOPB) begin
                    idx  <= '0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign frame = '{bits: shreg, stop_bad: 1'b0};

    // R4
    sync_done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(sclk_stb && en));
endmodule

// File: rtl/dmrx_flags.sv
module dmrx_flags
    import dmrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              is_async,
    input  logic              rd_stb,
    input  logic              err_clr,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_addr,
    output logic              rx_full,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              data_valid,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_addr <= 1'b0;
            rx_full <= 1'b0;
            ovr_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            if (rd_stb) rx_full <= 1'b0;
            if (err_clr) begin
                ovr_err <= 1'b0;
                frm_err <= 1'b0;
            end
            if (done) begin
                if (is_async && frame.stop_bad) frm_err <= 1'b1;
                if (rx_full && !rd_stb) begin
                    ovr_err <= 1'b1;
                end else begin
                    rx_data <= frame.bits[DATA_W-1:0];
                    rx_addr <= is_async ? frame.bits[FRAME_W-1] : 1'b0;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    assign data_valid = rx_full && !ovr_err && !frm_err;
    assign irq        = irq_en && (rx_full || ovr_err || frm_err);

    // R7
    read_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !done) |=> !rx_full);
    // R6
    overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rx_full && !rd_stb) |=> (ovr_err && $stable(rx_data) && $stable(rx_addr)));
    // R2
    full_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(done));
    // R5
    frm_only_async_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_err) |-> $past(done && is_async));
endmodule

// File: rtl/dual_mode_rx.sv
module dual_mode_rx
    import dmrx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              ser_in,
    input  logic              os_tick,
    input  logic              sclk_stb,
    input  logic              rd_stb,
    input  logic              err_clr,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_addr,
    output logic              rx_full,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              data_valid,
    output logic              irq
);
    rx_mode_e  mode;
    logic      a_done, s_done, f_done;
    rx_frame_t a_frame, s_frame, f_frame;

    assign mode = rx_mode_e'(mode_sel);

    dmrx_async #(.OS_RATE(OS_RATE)) u_async (
        .clk(clk), .rst(rst), .en(mode == MODE_ASYNC), .os_tick(os_tick),
        .ser_in(ser_in), .done(a_done), .frame(a_frame)
    );

    dmrx_sync u_sync (
        .clk(clk), .rst(rst), .en(mode == MODE_SYNC), .sclk_stb(sclk_stb),
        .ser_in(ser_in), .done(s_done), .frame(s_frame)
    );

    assign f_done  = (mode == MODE_ASYNC) ? a_done  : s_done;
    assign f_frame = (mode == MODE_ASYNC) ? a_frame : s_frame;

    dmrx_flags u_flags (
        .clk(clk), .rst(rst), .done(f_done), .frame(f_frame),
        .is_async(mode == MODE_ASYNC), .rd_stb(rd_stb), .err_clr(err_clr),
        .irq_en(irq_en), .rx_data(rx_data), .rx_addr(rx_addr),
        .rx_full(rx_full), .ovr_err(ovr_err), .frm_err(frm_err),
        .data_valid(data_valid), .irq(irq)
    );
endmodule

// File: tb/sim_dual_mode_rx.sv
module sim_dual_mode_rx;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_T      = 16;

    typedef struct packed {
        logic       mode;
        logic [8:0] bits;
        logic       stop;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{mode: 1'b0, bits: 9'h0A5, stop: 1'b1},
        '{mode: 1'b0, bits: 9'h13C, stop: 1'b1},
        '{mode: 1'b0, bits: 9'h181, stop: 1'b0},
        '{mode: 1'b1, bits: 9'h05A, stop: 1'b1},
        '{mode: 1'b1, bits: 9'h1FF, stop: 1'b0},
        '{mode: 1'b0, bits: 9'h000, stop: 1'b1}
    };

    logic clk = 1'b0;
    logic rst, mode_sel, ser_in, os_tick, sclk_stb, rd_stb, err_clr, irq_en;
    logic [7:0] rx_data;
    logic rx_addr, rx_full, ovr_err, frm_err, data_valid, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_mode_rx u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ser_in(ser_in),
        .os_tick(os_tick), .sclk_stb(sclk_stb), .rd_stb(rd_stb),
        .err_clr(err_clr), .irq_en(irq_en), .rx_data(rx_data),
        .rx_addr(rx_addr), .rx_full(rx_full), .ovr_err(ovr_err),
        .frm_err(frm_err), .data_valid(data_valid), .irq(irq)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic b, input int n);
        ser_in = b;
        repeat (n) @(negedge clk);
    endtask

    // early_full: value rx_full must still show at the start of the stop bit
    task automatic send_async(input logic [8:0] bits, input logic stop, input logic early_full);
        hold(1'b0, BIT_T);
        for (int i = 0; i < 9; i++) hold(bits[i], BIT_T);
        check("R2 flags unchanged before stop sample", {8'h0, rx_full}, {8'h0, early_full});
        hold(stop, BIT_T);
        hold(1'b1, 4);
    endtask

    task automatic send_sync(input logic [7:0] b, input logic early_full);
        for (int i = 0; i < 8; i++) begin
            if (i == 7)
                check("R4 no update before eighth bit", {8'h0, rx_full}, {8'h0, early_full});
            ser_in = b[i];
            sclk_stb = 1'b1;
            @(negedge clk);
            sclk_stb = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_rd_clr();
        rd_stb = 1'b1;
        err_clr = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode_sel = 1'b0; ser_in = 1'b1; os_tick = 1'b1;
        sclk_stb = 1'b0; rd_stb = 1'b0; err_clr = 1'b0; irq_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check("R10 rx_full", {8'h0, rx_full}, 9'h0);
        check("R10 ovr/frm", {7'h0, ovr_err, frm_err}, 9'h0);
        check("R10 rx_data/addr", {rx_addr, rx_data}, 9'h0);
        check("R10 irq/valid", {7'h0, irq, data_valid}, 9'h0);

        // Vector table: R1 R3 R4 R5 R8 R9
        for (int v = 0; v < NV; v++) begin
            mode_sel = VECS[v].mode;
            @(negedge clk);
            if (VECS[v].mode == 1'b0) begin
                send_async(VECS[v].bits, VECS[v].stop, 1'b0);
                check("R1 async byte and address bit", {rx_addr, rx_data}, VECS[v].bits);
                check("R3 framing flag", {8'h0, frm_err}, {8'h0, ~VECS[v].stop});
            end else begin
                send_sync(VECS[v].bits[7:0], 1'b0);
                check("R4 sync byte, addr 0", {rx_addr, rx_data}, {1'b0, VECS[v].bits[7:0]});
                check("R5 sync never frames", {8'h0, frm_err}, 9'h0);
            end
            check("R2 rx_full set", {8'h0, rx_full}, 9'h1);
            check("R8 data_valid",
                  {8'h0, data_valid}, {8'h0, ~(VECS[v].mode == 1'b0 && !VECS[v].stop)});
            check("R9 irq raised", {8'h0, irq}, 9'h1);
            pulse_rd_clr();
            check("R7 read and clear", {6'h0, rx_full, ovr_err, frm_err}, 9'h0);
        end

        // R6 async overrun, R9 irq held until all flags clear
        mode_sel = 1'b0;
        @(negedge clk);
        send_async(9'h0A5, 1'b1, 1'b0);
        send_async(9'h13C, 1'b1, 1'b1);
        check("R6 earlier byte kept", {rx_addr, rx_data}, 9'h0A5);
        check("R6 overrun set", {7'h0, ovr_err, rx_full}, 9'h3);
        check("R8 invalid on overrun", {8'h0, data_valid}, 9'h0);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R9 irq held by overrun", {7'h0, rx_full, irq}, 9'h1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R7 err_clr drops irq", {7'h0, ovr_err, irq}, 9'h0);

        // R9 enable gating
        irq_en = 1'b0;
        send_async(9'h055, 1'b1, 1'b0);
        check("R9 irq gated by enable", {7'h0, rx_full, irq}, 9'h2);
        irq_en = 1'b1;
        @(negedge clk);
        check("R9 irq on enable", {8'h0, irq}, 9'h1);
        pulse_rd_clr();

        // R1 short low pulse rejected
        hold(1'b0, 5);
        hold(1'b1, 200);
        check("R1 glitch ignored", {7'h0, rx_full, frm_err}, 9'h0);

        // R5 R6 sync overrun
        mode_sel = 1'b1;
        @(negedge clk);
        ser_in = 1'b0;
        send_sync(8'hC3, 1'b0);
        send_sync(8'h3C, 1'b1);
        check("R6 sync earlier byte kept", {rx_addr, rx_data}, 9'h0C3);
        check("R5 sync overrun without framing", {7'h0, ovr_err, frm_err}, 9'h2);
        pulse_rd_clr();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule